// File: doc/BRIEF.md
# Multi-mode SCL timing generator

This block drives the serial clock of a bus that carries both I3C and legacy I2C targets. It runs one down-counter off the core clock and builds every SCL period from a low count followed by a high count. Those counts come from one of five timing words: I3C open-drain, I3C push-pull, a word holding four reduced-rate push-pull low counts, I2C Fast-mode, and I2C Fast-mode Plus. A two-bit mode input picks the word. A three-bit speed code picks the reduced-rate low counts in push-pull mode.

A controller asks for a start when it wants the bus and a stop when it is done. The block turns a start into a stream of clock periods and finishes the period in progress before it honours a stop. It then holds SCL high and counts idle core cycles. A new start is refused until the programmed bus-free interval has passed. The block marks each SCL falling edge and each rising edge with a one-cycle strobe, so the data-line shifter can align to them.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held, and after it, scl is 1, both strobes are 0 and bus_free is 0 unless the bus-free count is 0. Reset restarts the idle count in the same way a stop does.
- R2: Each SCL period is exactly LO core cycles with scl at 0 followed by HI core cycles with scl at 1. After an accepted start, scl goes low in the cycle after the start_req sample.
- R3: With mode 0 (I3C open-drain), HI is od_timing[23:16] and LO is od_timing[7:0]. Any value below 5 is raised to 5. The other bits are ignored.
- R4: With mode 1 (I3C push-pull) and a speed code of 0 or 5..7, HI is pp_timing[23:16] and LO is pp_timing[7:0], each raised to at least 5.
- R5: With mode 1 and speed code k in 1..4, LO is ext_lcnt[8k-1:8k-8], raised to at least 5, and HI is still pp_timing[23:16].
- R6: With mode 2 (I2C Fast-mode), HI is fm_timing[31:16] and LO is fm_timing[15:0]. A count of 0 is raised to 1.
- R7: With mode 3 (I2C Fast-mode Plus), HI is fmp_timing[23:16] and LO is fmp_timing[15:0]. A count of 0 is raised to 1, and bits 31:24 are ignored.
- R8: Timing words, mode and speed are sampled only when a period starts. A change made during a period first shapes the next period.
- R9: bus_free goes to 1 when the bus has been idle for free_timing[15:0] core cycles since the last stop or reset. A start_req made while bus_free is 0 is dropped.
- R10: A stop_req made while the clock runs lets the current period finish its high phase. scl then stays at 1 with no further strobes.
- R11: fall_stb is a one-cycle pulse in the first low cycle of every period, and rise_stb is a one-cycle pulse in its first high cycle. Neither pulses at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| od_timing | input | 32 | I3C open-drain high/low counts |
| pp_timing | input | 32 | I3C push-pull high/low counts |
| ext_lcnt | input | 32 | Four 8-bit reduced-rate low counts |
| fm_timing | input | 32 | I2C Fast-mode high/low counts |
| fmp_timing | input | 32 | I2C Fast-mode Plus high/low counts |
| free_timing | input | 32 | Bus-free idle count in bits 15:0 |
| mode | input | 2 | 0 open-drain, 1 push-pull, 2 Fast-mode, 3 Fast-mode Plus |
| speed | input | 3 | Push-pull speed code |
| start_req | input | 1 | Request to start clocking |
| stop_req | input | 1 | Request to stop after the current period |
| scl | output | 1 | Serial clock level |
| fall_stb | output | 1 | First cycle after an SCL falling edge |
| rise_stb | output | 1 | First cycle after an SCL rising edge |
| bus_free | output | 1 | Idle long enough to accept a start |

## Verification
The bench puts junk in every unused bit of the timing words. A design that picked the wrong field or width then gives a visibly wrong period. It programs counts below the I3C minimum and counts of zero in the I2C words. A missing clamp shows up as a short phase, or as a phase that wraps through 65536 cycles. It rewrites a timing word in the first cycle of a period; a design that reloaded counts mid-period would stretch or cut that period. It also issues a start before the bus-free interval is over and counts the exact idle cycles before bus_free rises. An off-by-one or an accepted early start shows up as a wrong count or a stray falling edge.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CW      = 16,
  parameter int I3C_MIN = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] od_timing,
  input  logic [31:0] pp_timing,
  input  logic [31:0] ext_lcnt,
  input  logic [31:0] fm_timing,
  input  logic [31:0] fmp_timing,
  input  logic [31:0] free_timing,
  input  logic [1:0]  mode,
  input  logic [2:0]  speed,
  input  logic        start_req,
  input  logic        stop_req,
  output logic        scl,
  output logic        fall_stb,
  output logic        rise_stb,
  output logic        bus_free
);

  localparam logic [CW-1:0] MIN3 = CW'(I3C_MIN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  function automatic logic [CW-1:0] floor_at(input logic [CW-1:0] v, input logic [CW-1:0] m);
    return (v < m) ? m : v;
  endfunction

  logic [7:0]    ext_sel;
  logic [CW-1:0] sel_hi, sel_lo;

  always_comb begin
    case (speed)
      3'd1:    ext_sel = ext_lcnt[7:0];
      3'd2:    ext_sel = ext_lcnt[15:8];
      3'd3:    ext_sel = ext_lcnt[23:16];
      3'd4:    ext_sel = ext_lcnt[31:24];
      default: ext_sel = pp_timing[7:0];
    endcase
  end

  always_comb begin
    case (mode)
      2'd0: begin
        sel_hi = floor_at(CW'(od_timing[23:16]), MIN3);
        sel_lo = floor_at(CW'(od_timing[7:0]), MIN3);
      end
      2'd1: begin
        sel_hi = floor_at(CW'(pp_timing[23:16]), MIN3);
        sel_lo = floor_at(CW'(ext_sel), MIN3);
      end
      2'd2: begin
        sel_hi = floor_at(CW'(fm_timing[31:16]), ONE);
        sel_lo = floor_at(CW'(fm_timing[15:0]), ONE);
      end
      default: begin
        sel_hi = floor_at(CW'(fmp_timing[23:16]), ONE);
        sel_lo = floor_at(CW'(fmp_timing[15:0]), ONE);
      end
    endcase
  end

  wire unused_bits = ^{od_timing[31:24], od_timing[15:8], pp_timing[31:24],
                       pp_timing[15:8], fmp_timing[31:24], free_timing[31:16]};

  logic          busy, low_ph, stop_pend;
  logic [CW-1:0] cnt, hi_lat, free_cnt;

  wire free_ok = !busy && (free_cnt >= free_timing[15:0]);
  wire go      = start_req && free_ok;

  assign bus_free = free_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      low_ph    <= 1'b0;
      stop_pend <= 1'b0;
      scl       <= 1'b1;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
      cnt       <= '0;
      hi_lat    <= '0;
      free_cnt  <= '0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!busy) begin
        stop_pend <= 1'b0;
        if (free_cnt != '1) free_cnt <= free_cnt + ONE;
        if (go) begin
          busy     <= 1'b1;
          scl      <= 1'b0;
          low_ph   <= 1'b1;
          cnt      <= sel_lo - ONE;
          hi_lat   <= sel_hi;
          fall_stb <= 1'b1;
          free_cnt <= '0;
        end
      end else begin
        if (stop_req) stop_pend <= 1'b1;
        if (cnt != '0) begin
          cnt <= cnt - ONE;
        end else if (low_ph) begin
          low_ph   <= 1'b0;
          scl      <= 1'b1;
          rise_stb <= 1'b1;
          cnt      <= hi_lat - ONE;
        end else if (stop_pend || stop_req) begin
          busy     <= 1'b0;
          free_cnt <= '0;
        end else begin
          scl      <= 1'b0;
          low_ph   <= 1'b1;
          cnt      <= sel_lo - ONE;
          hi_lat   <= sel_hi;
          fall_stb <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fall_stb || rise_stb)); // R11

  AST_FALL_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl && $past(scl))); // R11

  AST_RISE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl && !$past(scl))); // R11

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_free)); // R9

  AST_FREE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> scl && !fall_stb); // R9

endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] od_timing = '0, pp_timing = '0, ext_lcnt = '0;
  logic [31:0] fm_timing = '0, fmp_timing = '0, free_timing = 32'd2;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  speed = 3'd0;
  logic        start_req = 1'b0, stop_req = 1'b0;
  logic        scl, fall_stb, rise_stb, bus_free;

  int errors = 0;
  int checks = 0;
  int free_val = 2;

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .od_timing(od_timing), .pp_timing(pp_timing),
    .ext_lcnt(ext_lcnt), .fm_timing(fm_timing), .fmp_timing(fmp_timing),
    .free_timing(free_timing), .mode(mode), .speed(speed),
    .start_req(start_req), .stop_req(stop_req), .scl(scl),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .bus_free(bus_free)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_free();
    for (int i = 0; i < 70000 && !bus_free; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic measure(input bit do_stop, input int lim,
                         output int lo, output int hi, output int nf,
                         output int nr, output int fb);
    lo = 0; hi = 0; nf = 0; nr = 0; fb = -1;
    while (scl == 1'b0 && lo < 70000) begin
      stop_req = do_stop && (lo == 0);
      if (fall_stb) nf++;
      if (rise_stb) nr++;
      lo++;
      @(negedge clk);
    end
    stop_req = 1'b0;
    while (scl == 1'b1 && hi < lim) begin
      if (rise_stb) nr++;
      if (fall_stb) nf++;
      if (bus_free && fb < 0) fb = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic do_run(input int exp_lo, input int exp_hi, input string req);
    int lo, hi, nf, nr, fb, lim;
    lim = exp_hi + free_val + 12;
    wait_free();
    pulse_start();
    chk(scl == 1'b0 && fall_stb, "R2", scl, 0);
    measure(1'b0, lim, lo, hi, nf, nr, fb);
    chk(lo == exp_lo, req, lo, exp_lo);
    chk(hi == exp_hi, req, hi, exp_hi);
    chk(nf == 1 && nr == 1, "R11", nf * 10 + nr, 11);
    chk(fb == -1, "R9", fb, -1);
    measure(1'b1, lim, lo, hi, nf, nr, fb);
    chk(lo == exp_lo, req, lo, exp_lo);
    chk(hi == lim && nr == 1 && nf == 1, "R10", hi, lim);
    chk(fb == exp_hi + free_val, "R9", fb, exp_hi + free_val);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(scl == 1'b1, "R1", scl, 1);
    chk(!fall_stb && !rise_stb, "R1", fall_stb + rise_stb, 0);
    chk(bus_free == 1'b0, "R1", bus_free, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bus_free == 1'b1 && scl == 1'b1, "R1", bus_free, 1);
  endtask

  task automatic t_open_drain();
    mode = 2'd0; speed = 3'd3;
    od_timing = {8'hAA, 8'd7, 8'hBB, 8'd9};
    do_run(9, 7, "R3");
    od_timing = {8'hFF, 8'd2, 8'hFF, 8'd0};
    do_run(5, 5, "R3");
    speed = 3'd0;
  endtask

  task automatic t_push_pull();
    mode = 2'd1;
    pp_timing = {8'hCC, 8'd6, 8'hDD, 8'd8};
    ext_lcnt  = {8'd16, 8'd14, 8'd3, 8'd10};
    speed = 3'd0; do_run(8, 6, "R4");
    speed = 3'd6; do_run(8, 6, "R4");
    speed = 3'd1; do_run(10, 6, "R5");
    speed = 3'd2; do_run(5, 6, "R5");
    speed = 3'd3; do_run(14, 6, "R5");
    speed = 3'd4; do_run(16, 6, "R5");
    speed = 3'd0;
  endtask

  task automatic t_i2c();
    mode = 2'd2;
    fm_timing = {16'd300, 16'd400};
    do_run(400, 300, "R6");
    fm_timing = '0;
    do_run(1, 1, "R6");
    mode = 2'd3;
    fmp_timing = {8'hEE, 8'd20, 16'd600};
    do_run(600, 20, "R7");
  endtask

  task automatic t_midchange();
    int lo, hi, nf, nr, fb;
    mode = 2'd0;
    od_timing = {8'h00, 8'd7, 8'h00, 8'd9};
    wait_free();
    pulse_start();
    od_timing = {8'h00, 8'd8, 8'h00, 8'd6};
    measure(1'b0, 40, lo, hi, nf, nr, fb);
    chk(lo == 9, "R8", lo, 9);
    chk(hi == 7, "R8", hi, 7);
    measure(1'b1, 40, lo, hi, nf, nr, fb);
    chk(lo == 6, "R8", lo, 6);
    chk(fb == 8 + free_val, "R8", fb, 8 + free_val);
  endtask

  task automatic t_bus_free();
    int lo, hi, nf, nr, fb, n;
    bit quiet;
    free_val = 20; free_timing = {16'hFFFF, 16'd20};
    mode = 2'd0;
    od_timing = {8'h00, 8'd5, 8'h00, 8'd5};
    wait_free();
    pulse_start();
    measure(1'b0, 40, lo, hi, nf, nr, fb);
    measure(1'b1, 5 + 4, lo, hi, nf, nr, fb);
    chk(bus_free == 1'b0, "R9", bus_free, 0);
    pulse_start();
    quiet = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (scl !== 1'b1 || fall_stb !== 1'b0) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R9", quiet, 1);
    n = 0;
    while (!bus_free && n < 100) begin n++; @(negedge clk); end
    chk(n == 9, "R9", n, 9);
    pulse_start();
    chk(scl == 1'b0 && fall_stb, "R9", scl, 0);
    measure(1'b1, 60, lo, hi, nf, nr, fb);
    chk(lo == 5 && fb == 25, "R9", fb, 25);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    t_reset();
    t_open_drain();
    t_push_pull();
    t_i2c();
    t_midchange();
    t_bus_free();
    finish_up();
  end
endmodule